// File: doc/BRIEF.md
# PSRAM Host Controller with Refresh

This block connects a synchronous host to a 256K x 16 pseudo-static RAM. The host presents one request at a time on a valid/ready port: an 18-bit word address, a read/write flag, 16 bits of write data and a two-bit byte mask. The controller turns each request into one memory cycle on the RAM's strobes, its address pins and a split bidirectional data bus. Every read returns its word on a single-cycle response strobe. All timing limits are given in nanoseconds as parameters. They are converted to whole clock cycles by rounding up against a clock-frequency parameter.

Because the RAM is dynamic inside, the controller also keeps it alive without help from the host. After reset it holds the chip idle for the power-up pause, then runs a fixed number of dummy chip-enable cycles before it accepts any traffic. From then on, an interval timer raises a refresh demand about every 15.6 us. A demand is served with a short low pulse on the refresh pin while chip enable is high. It waits only for the memory cycle already running and is served ahead of any request the host is holding.

A host level input, `sleep_req`, parks the RAM in self-refresh. The refresh pin is held low for at least the minimum self-refresh time and for as long as the request stays high. On exit, the controller waits out the recovery time and then issues an auto-refresh pulse at once.

Top module: `psram_ctrl`

## Requirements
- R1: After reset, `mem_ce_n` and `mem_rfsh_n` are high and `req_ready` is low for PWR_CYC cycles. The controller then makes exactly DUMMY_CYCLES chip-enable low pulses, with `mem_oe_n`, `mem_uwe_n` and `mem_lwe_n` high. `req_ready` first rises PWR_CYC + DUMMY_CYCLES*(LOW_CYC+PRE_CYC) cycles after reset is released.
- R2: The request address goes out unchanged on `mem_addr`: bits 0-6 are the column and bits 7-17 are the row. It is valid at least one cycle before `mem_ce_n` falls and is held stable while `mem_ce_n` is low.
- R3: During a read, `mem_oe_n` is low only while `mem_ce_n` is low, `mem_sel` is high, `mem_rfsh_n` is high and both write enables are high. The data bus is sampled in the last chip-enable-low cycle. `rsp_valid` is high, carrying that word, in the first cycle after `mem_ce_n` returns high.
- R4: During a write, mask bit 1 drives `mem_uwe_n` low (bits 15:8) and mask bit 0 drives `mem_lwe_n` low (bits 7:0). With both bits set, the two strobes fall and rise on the same edges. With mask 00, neither strobe falls and the memory is left unchanged.
- R5: `mem_dq_oe` is high only while chip enable and at least one write strobe are low; the bus is released at all other times.
- R6: Every chip-enable low pulse lasts exactly LOW_CYC cycles, covering both the minimum low width and the access time. The following high time is at least PRE_CYC cycles, with LOW_CYC + PRE_CYC covering the minimum cycle time.
- R7: Refresh demands arise every REFI_CYC cycles. Each auto-refresh drives `mem_rfsh_n` low for exactly RFP_CYC cycles while `mem_ce_n` is high, followed by at least REC_CYC cycles of recovery. In an idle controller, successive pulses start exactly REFI_CYC cycles apart.
- R8: A pending refresh lets any running memory cycle finish and is then served before a waiting host request. `req_ready` is low while a refresh is pending or the refresh pin is low.
- R9: While idle, a high `sleep_req` drops `mem_rfsh_n` with `mem_ce_n` high. The pin stays low for at least SRMIN_CYC cycles and until `sleep_req` falls, and `req_ready` stays low throughout.
- R10: After self-refresh ends, `mem_rfsh_n` stays high for exactly SRX_CYC cycles. An auto-refresh pulse of RFP_CYC cycles follows immediately, well inside the 15 us limit.
- R11: Each accepted read gives exactly one single-cycle `rsp_valid` pulse. A write gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address (bits 0-6 column, 7-17 row) |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Byte lanes to write: bit 1 upper, bit 0 lower |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data |
| sleep_req | input | 1 | Level request for self-refresh |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_sel | output | 1 | Memory chip select, active high |
| mem_rfsh_n | output | 1 | Memory refresh pin, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_uwe_n | output | 1 | Upper byte write strobe, active low |
| mem_lwe_n | output | 1 | Lower byte write strobe, active low |
| mem_addr | output | 18 | Memory address |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data bus driver |
| mem_dq_i | input | 16 | Data returned from the memory |

## Verification
The in-RTL properties watch, on every cycle, the electrical rules that must never break. These are: refresh only with chip enable high, paired strobes, the bus driver confined to the strobe window, the exact chip-enable low width, a stable address while chip enable is low, no ready while refresh is pending, and one-cycle responses. Other behaviours can only be shown by the bench's scenarios, because each spans many cycles or needs a memory behind the pins. These are: byte-lane merging and the no-op mask, the exact power-up length and dummy count, the idle refresh spacing, refresh winning over a continuous stream of reads, and the self-refresh hold and exit gap.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [3:0] {
    S_PWR,    // power-up pause, chip idle
    S_DLOW,   // dummy cycle, chip enable low
    S_DPRE,   // dummy cycle, precharge
    S_IDLE,
    S_SETUP,  // address out, chip enable still high
    S_LOW,    // access, chip enable low
    S_PRE,    // access precharge
    S_RFP,    // auto-refresh pulse
    S_RFR,    // auto-refresh recovery
    S_SRH,    // self-refresh hold
    S_SRX     // self-refresh exit recovery
  } seq_state_e;

  // Round a duration in ns up to whole cycles of a clock given in MHz.
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int unsigned at_least(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Cycles still needed to fill a total after 'used', but never below floor_v.
  function automatic int unsigned fill_to(input int unsigned total, input int unsigned used,
                                          input int unsigned floor_v);
    return (total > used + floor_v) ? (total - used) : floor_v;
  endfunction

endpackage

// File: rtl/psram_refresh_timer.sv
module psram_refresh_timer #(
  parameter int unsigned REFI_CYC = 3900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic served,
  output logic pending
);
  localparam int unsigned W = $clog2(REFI_CYC) + 1;

  logic [W-1:0] cnt;
  logic         interval_tick;

  assign interval_tick = enable && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= W'(REFI_CYC - 1);
      pending <= 1'b0;
    end else begin
      if (enable) cnt <= interval_tick ? W'(REFI_CYC - 1) : cnt - 1'b1;
      if (interval_tick)  pending <= 1'b1;
      else if (served)    pending <= 1'b0;
    end
  end

  // R7: every interval expiry raises a demand
  p_tick_raises_r7: assert property (@(posedge clk) disable iff (!rst_n)
    interval_tick |=> pending);
  // R8: a demand is dropped only when a refresh has been served
  p_pending_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !served) |=> pending);

endmodule

// File: rtl/psram_sequencer.sv
module psram_sequencer
  import psram_pkg::*;
#(
  parameter int unsigned PWR_CYC      = 125000,
  parameter int unsigned DUMMY_CYCLES = 8,
  parameter int unsigned LOW_CYC      = 30,
  parameter int unsigned PRE_CYC      = 18,
  parameter int unsigned RFP_CYC      = 20,
  parameter int unsigned REC_CYC      = 28,
  parameter int unsigned SRMIN_CYC    = 2000,
  parameter int unsigned SRX_CYC      = 150
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [1:0] req_bmask,
  input  logic       sleep_req,
  input  logic       rf_pending,
  output logic       req_ready,
  output logic       accept,
  output logic       cap_read,
  output logic       rf_served,
  output logic       init_done,
  output logic       drive_en,
  output logic       mem_ce_n,
  output logic       mem_sel,
  output logic       mem_rfsh_n,
  output logic       mem_oe_n,
  output logic       mem_uwe_n,
  output logic       mem_lwe_n
);
  localparam int unsigned MAXC = at_least(at_least(at_least(PWR_CYC, LOW_CYC), at_least(PRE_CYC, RFP_CYC)),
                                          at_least(at_least(REC_CYC, SRMIN_CYC), SRX_CYC));
  localparam int unsigned CNT_W = $clog2(MAXC) + 1;
  localparam int unsigned DUM_W = $clog2(DUMMY_CYCLES) + 1;
  localparam int unsigned RUN_W = $clog2(LOW_CYC + 1) + 1;

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [DUM_W-1:0] dummy_left;
  logic             op_write;
  logic [1:0]       op_mask;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_PWR;
      cnt        <= CNT_W'(PWR_CYC - 1);
      dummy_left <= DUM_W'(DUMMY_CYCLES - 1);
      init_done  <= 1'b0;
      op_write   <= 1'b0;
      op_mask    <= 2'b00;
    end else begin
      case (state)
        S_PWR: if (cnt_zero) begin
          state <= S_DLOW; cnt <= CNT_W'(LOW_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_DLOW: if (cnt_zero) begin
          state <= S_DPRE; cnt <= CNT_W'(PRE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_DPRE: if (cnt_zero) begin
          if (dummy_left == '0) begin
            state <= S_IDLE; init_done <= 1'b1;
          end else begin
            dummy_left <= dummy_left - 1'b1;
            state <= S_DLOW; cnt <= CNT_W'(LOW_CYC - 1);
          end
        end else cnt <= cnt - 1'b1;
        S_IDLE: if (rf_pending) begin
          state <= S_RFP; cnt <= CNT_W'(RFP_CYC - 1);
        end else if (sleep_req) begin
          state <= S_SRH; cnt <= CNT_W'(SRMIN_CYC - 1);
        end else if (req_valid) begin
          state <= S_SETUP; op_write <= req_write; op_mask <= req_bmask;
        end
        S_SETUP: begin
          state <= S_LOW; cnt <= CNT_W'(LOW_CYC - 1);
        end
        S_LOW: if (cnt_zero) begin
          state <= S_PRE; cnt <= CNT_W'(PRE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_PRE: if (cnt_zero) state <= S_IDLE;
               else cnt <= cnt - 1'b1;
        S_RFP: if (cnt_zero) begin
          state <= S_RFR; cnt <= CNT_W'(REC_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_RFR: if (cnt_zero) state <= S_IDLE;
               else cnt <= cnt - 1'b1;
        S_SRH: if (!cnt_zero) cnt <= cnt - 1'b1;
               else if (!sleep_req) begin
                 state <= S_SRX; cnt <= CNT_W'(SRX_CYC - 1);
               end
        S_SRX: if (cnt_zero) begin
          state <= S_RFP; cnt <= CNT_W'(RFP_CYC - 1);
        end else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  // Named events and pin decode
  assign req_ready  = (state == S_IDLE) && !rf_pending && !sleep_req;
  assign accept     = req_ready && req_valid;
  assign cap_read   = (state == S_LOW) && !op_write && cnt_zero;
  assign rf_served  = (state == S_RFR) && cnt_zero;
  assign drive_en   = (state == S_LOW) && op_write && (op_mask != 2'b00);
  assign mem_ce_n   = !((state == S_DLOW) || (state == S_LOW));
  assign mem_sel    = state inside {S_DLOW, S_DPRE, S_SETUP, S_LOW, S_PRE};
  assign mem_rfsh_n = !((state == S_RFP) || (state == S_SRH));
  assign mem_oe_n   = !((state == S_LOW) && !op_write);
  assign mem_uwe_n  = !((state == S_LOW) && op_write && op_mask[1]);
  assign mem_lwe_n  = !((state == S_LOW) && op_write && op_mask[0]);

  // Run length of chip-enable low, kept for the width property
  logic [RUN_W-1:0] ce_low_run;
  always_ff @(posedge clk) begin
    if (!rst_n)         ce_low_run <= '0;
    else if (!mem_ce_n) ce_low_run <= ce_low_run + 1'b1;
    else                ce_low_run <= '0;
  end

  p_no_ready_in_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !req_ready);
  p_oe_read_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_sel && mem_rfsh_n && mem_uwe_n && mem_lwe_n));
  p_strobes_paired_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_uwe_n && !mem_lwe_n) |-> ($past(mem_uwe_n) == $past(mem_lwe_n)));
  p_drive_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> (!mem_ce_n && (!mem_uwe_n || !mem_lwe_n)));
  p_ce_low_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> (ce_low_run == RUN_W'(LOW_CYC)));
  p_rfsh_ce_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rfsh_n |-> mem_ce_n);
  p_pending_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_pending || !mem_rfsh_n) |-> !req_ready);
  p_sleep_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> !req_ready);

endmodule

// File: rtl/psram_datapath.sv
module psram_datapath #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cap_read,
  input  logic              drive_en,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        mem_dq_o <= req_wdata;
      end
      rsp_valid <= cap_read;
      if (cap_read) rsp_rdata <= mem_dq_i;
    end
  end

  assign mem_dq_oe = drive_en;

  // R11: a response lasts one cycle
  p_rsp_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 250,
  parameter int unsigned ADDR_W       = 18,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned T_RC_NS      = 190,
  parameter int unsigned T_CE_NS      = 120,
  parameter int unsigned T_PRE_NS     = 60,
  parameter int unsigned T_ACC_NS     = 120,
  parameter int unsigned T_PWR_NS     = 500000,
  parameter int unsigned DUMMY_CYCLES = 8,
  parameter int unsigned T_REFI_NS    = 15600,
  parameter int unsigned T_RFP_NS     = 80,
  parameter int unsigned T_SRMIN_NS   = 8000,
  parameter int unsigned T_SRX_NS     = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_bmask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              sleep_req,
  output logic              mem_ce_n,
  output logic              mem_sel,
  output logic              mem_rfsh_n,
  output logic              mem_oe_n,
  output logic              mem_uwe_n,
  output logic              mem_lwe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned RC_CYC    = ns_to_cycles(T_RC_NS, CLK_MHZ);
  localparam int unsigned LOW_CYC   = at_least(ns_to_cycles(T_CE_NS, CLK_MHZ), ns_to_cycles(T_ACC_NS, CLK_MHZ));
  localparam int unsigned PRE_CYC   = fill_to(RC_CYC, LOW_CYC, ns_to_cycles(T_PRE_NS, CLK_MHZ));
  localparam int unsigned RFP_CYC   = at_least(ns_to_cycles(T_RFP_NS, CLK_MHZ), 1);
  localparam int unsigned REC_CYC   = fill_to(RC_CYC, RFP_CYC, 1);
  localparam int unsigned PWR_CYC   = at_least(ns_to_cycles(T_PWR_NS, CLK_MHZ), 1);
  localparam int unsigned REFI_CYC  = ns_to_cycles(T_REFI_NS, CLK_MHZ);
  localparam int unsigned SRMIN_CYC = at_least(ns_to_cycles(T_SRMIN_NS, CLK_MHZ), 1);
  localparam int unsigned SRX_CYC   = at_least(ns_to_cycles(T_SRX_NS, CLK_MHZ), 1);

  logic accept, cap_read, rf_served, rf_pending, init_done, drive_en;

  psram_refresh_timer #(.REFI_CYC(REFI_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(init_done), .served(rf_served), .pending(rf_pending)
  );

  psram_sequencer #(
    .PWR_CYC(PWR_CYC), .DUMMY_CYCLES(DUMMY_CYCLES), .LOW_CYC(LOW_CYC), .PRE_CYC(PRE_CYC),
    .RFP_CYC(RFP_CYC), .REC_CYC(REC_CYC), .SRMIN_CYC(SRMIN_CYC), .SRX_CYC(SRX_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bmask(req_bmask), .sleep_req(sleep_req), .rf_pending(rf_pending),
    .req_ready(req_ready), .accept(accept), .cap_read(cap_read), .rf_served(rf_served),
    .init_done(init_done), .drive_en(drive_en), .mem_ce_n(mem_ce_n), .mem_sel(mem_sel),
    .mem_rfsh_n(mem_rfsh_n), .mem_oe_n(mem_oe_n), .mem_uwe_n(mem_uwe_n), .mem_lwe_n(mem_lwe_n)
  );

  psram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr), .req_wdata(req_wdata),
    .cap_read(cap_read), .drive_en(drive_en), .mem_dq_i(mem_dq_i), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // R2: the address never moves while chip enable is low
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$fell(mem_ce_n)) |-> $stable(mem_addr));
  // R5: the bus driver is off whenever chip enable is high
  p_bus_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> !mem_dq_oe);

endmodule

// File: tb/psram_ctrl_test.sv
module psram_ctrl_test;
  // Expected cycle counts at a 4 ns clock: ceil(ns / 4)
  localparam int PWR   = (4000 + 3) / 4;        // bench shortens the pause
  localparam int LOW   = (120 + 3) / 4;
  localparam int PRE   = ((190 + 3) / 4) - LOW;  // 18 > ceil(60/4)
  localparam int RFP   = (80 + 3) / 4;
  localparam int REFI  = (15600 + 3) / 4;
  localparam int SRMIN = (8000 + 3) / 4;
  localparam int SRX   = (600 + 3) / 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, sleep_req = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_bmask = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_sel, mem_rfsh_n, mem_oe_n, mem_uwe_n, mem_lwe_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_dq_o, mem_dq_i;
  logic [17:0] mem_addr;

  always #2 clk = ~clk;

  psram_ctrl #(.T_PWR_NS(4000)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .sleep_req(sleep_req), .mem_ce_n(mem_ce_n), .mem_sel(mem_sel),
    .mem_rfsh_n(mem_rfsh_n), .mem_oe_n(mem_oe_n), .mem_uwe_n(mem_uwe_n), .mem_lwe_n(mem_lwe_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Small memory model indexed by the low address byte
  logic [15:0] model [256];
  initial for (int i = 0; i < 256; i++) model[i] = 16'h0000;
  always @(posedge clk) if (!mem_ce_n && mem_dq_oe) begin
    if (!mem_uwe_n) model[mem_addr[7:0]][15:8] <= mem_dq_o[15:8];
    if (!mem_lwe_n) model[mem_addr[7:0]][7:0]  <= mem_dq_o[7:0];
  end
  assign mem_dq_i = (!mem_ce_n && !mem_oe_n) ? model[mem_addr[7:0]] : 16'h0000;

  int tests = 0, fails = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Pin monitor, sampled at the falling edge
  int cyc = 0, ce_falls = 0, ce_lo = 0, ce_hi = 0, rf_lo = 0, rf_hi = 0;
  int last_rf_lo = 0, last_rf_hi = 0, rf_falls = 0, rf_fall_t = 0, prev_rf_fall_t = 0, rsp_cnt = 0;
  int v_addr = 0, v_ce = 0, v_strb = 0, v_read = 0, v_drv = 0, v_rf = 0, v_init = 0;
  bit init_seen = 0, prev_ce_n = 1, prev_rf_n = 1;
  logic [17:0] exp_addr = '0;
  logic [1:0]  cur_mask = 2'b00;
  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (rsp_valid) rsp_cnt++;
    if (!mem_ce_n) begin
      if (prev_ce_n) begin
        ce_falls++;
        if (init_seen && ce_hi < PRE) v_ce++;
        if (init_seen && mem_addr != exp_addr) v_addr++;
      end else if (init_seen && mem_addr != exp_addr) v_addr++;
      ce_lo++; ce_hi = 0;
    end else begin
      if (!prev_ce_n && ce_lo != LOW) v_ce++;
      ce_lo = 0; ce_hi++;
    end
    if (!init_seen && (!mem_oe_n || !mem_uwe_n || !mem_lwe_n)) v_init++;
    if ((!mem_uwe_n || !mem_lwe_n) && (mem_uwe_n != !cur_mask[1] || mem_lwe_n != !cur_mask[0])) v_strb++;
    if (!mem_oe_n && (mem_ce_n || !mem_sel || !mem_rfsh_n || !mem_uwe_n || !mem_lwe_n)) v_read++;
    if (mem_dq_oe && (mem_ce_n || (mem_uwe_n && mem_lwe_n))) v_drv++;
    if (!mem_rfsh_n && (!mem_ce_n || req_ready)) v_rf++;
    if (sleep_req && req_ready) v_rf++;
    if (!mem_rfsh_n) begin
      if (prev_rf_n) begin
        rf_falls++; last_rf_hi = rf_hi; prev_rf_fall_t = rf_fall_t; rf_fall_t = cyc;
      end
      rf_lo++; rf_hi = 0;
    end else begin
      if (!prev_rf_n) last_rf_lo = rf_lo;
      rf_lo = 0; rf_hi++;
    end
    prev_ce_n = mem_ce_n; prev_rf_n = mem_rfsh_n;
  end

  task automatic tick;
    @(negedge clk); #1;
  endtask

  int reads_issued = 0;
  task automatic do_op(input bit wr, input logic [1:0] mask, input logic [17:0] addr,
                       input logic [15:0] data, input logic [15:0] exp, input string tag);
    tick;
    req_valid = 1'b1; req_write = wr; req_bmask = mask; req_addr = addr; req_wdata = data;
    cur_mask = wr ? mask : 2'b00; exp_addr = addr;
    while (!req_ready) tick;
    tick;
    req_valid = 1'b0;
    while (mem_ce_n) tick;
    while (!mem_ce_n) tick;
    if (!wr) begin
      reads_issued++;
      check(rsp_valid === 1'b1 && rsp_rdata === exp, tag, {15'd0, rsp_valid, rsp_rdata}, {16'd1, exp});
    end else begin
      check(rsp_valid === 1'b0, "R11 write gives no response", int'(rsp_valid), 0);
    end
  endtask

  // {write, mask, addr, wdata, expected read}
  localparam logic [52:0] VEC [13] = '{
    {1'b1, 2'b11, 18'h00010, 16'h1234, 16'h0000},
    {1'b0, 2'b00, 18'h00010, 16'h0000, 16'h1234},
    {1'b1, 2'b10, 18'h00010, 16'hAB99, 16'h0000},
    {1'b0, 2'b00, 18'h00010, 16'h0000, 16'hAB34},
    {1'b1, 2'b01, 18'h00010, 16'h77CD, 16'h0000},
    {1'b0, 2'b00, 18'h00010, 16'h0000, 16'hABCD},
    {1'b1, 2'b00, 18'h00010, 16'hFFFF, 16'h0000},
    {1'b0, 2'b00, 18'h00010, 16'h0000, 16'hABCD},
    {1'b1, 2'b11, 18'h3FF21, 16'h5A5A, 16'h0000},
    {1'b0, 2'b00, 18'h3FF21, 16'h0000, 16'h5A5A},
    {1'b0, 2'b00, 18'h00010, 16'h0000, 16'hABCD},
    {1'b1, 2'b11, 18'h2A0C3, 16'h0F0F, 16'h0000},
    {1'b0, 2'b00, 18'h2A0C3, 16'h0000, 16'h0F0F}
  };

  bit finished = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n, f0, rsp0;
    repeat (3) tick;
    // R1: reset state
    check(mem_ce_n && mem_rfsh_n && !req_ready && !rsp_valid && !mem_dq_oe, "R1 reset pins",
          {mem_ce_n, mem_rfsh_n, req_ready, rsp_valid, mem_dq_oe}, 5'b11000);
    rst_n = 1'b1;
    n = 0;
    while (!req_ready) begin tick; n++; end
    check(n == PWR + 8 * (LOW + PRE), "R1 cycles to first ready", n, PWR + 8 * (LOW + PRE));
    check(ce_falls == 8, "R1 dummy cycle count", ce_falls, 8);
    check(v_init == 0, "R1 no strobes during init", v_init, 0);
    init_seen = 1;

    // Vector walk: R2 R3 R4 R11
    for (int i = 0; i < 13; i++)
      do_op(VEC[i][52], VEC[i][51:50], VEC[i][49:32], VEC[i][31:16], VEC[i][15:0],
            VEC[i][51:50] == 2'b00 ? "R4 masked-off write keeps word" : "R3 R4 read data");

    // R7: idle refresh spacing and pulse width
    f0 = rf_falls;
    while (rf_falls < f0 + 2) tick;
    check(rf_fall_t - prev_rf_fall_t == REFI, "R7 idle refresh interval", rf_fall_t - prev_rf_fall_t, REFI);
    while (!mem_rfsh_n) tick;
    check(last_rf_lo == RFP, "R7 refresh pulse width", last_rf_lo, RFP);

    // R8: refresh wins against a continuous stream of reads
    f0 = rf_falls;
    for (int i = 0; i < 100; i++) do_op(1'b0, 2'b00, 18'h00010, 16'h0, 16'hABCD, "R8 read during refresh stream");
    check(rf_falls > f0, "R8 refresh inside read stream", rf_falls - f0, 1);

    // R9 R10: self-refresh, early release
    f0 = rf_falls;
    while (rf_falls == f0) tick;
    while (!mem_rfsh_n) tick;
    repeat (40) tick;
    sleep_req = 1'b1;
    while (mem_rfsh_n) tick;
    repeat (100) tick;
    sleep_req = 1'b0;
    while (!mem_rfsh_n) tick;
    check(last_rf_lo == SRMIN, "R9 minimum self-refresh hold", last_rf_lo, SRMIN);
    while (mem_rfsh_n) tick;
    check(last_rf_hi == SRX, "R10 exit gap before refresh", last_rf_hi, SRX);
    while (!mem_rfsh_n) tick;
    check(last_rf_lo == RFP, "R10 refresh pulse after exit", last_rf_lo, RFP);

    // R9: long hold follows the request
    repeat (40) tick;
    sleep_req = 1'b1;
    while (mem_rfsh_n) tick;
    repeat (2500) tick;
    sleep_req = 1'b0;
    while (!mem_rfsh_n) tick;
    check(last_rf_lo == 2501, "R9 hold follows sleep request", last_rf_lo, 2501);
    while (!req_ready) tick;
    rsp0 = rsp_cnt;
    do_op(1'b0, 2'b00, 18'h3FF21, 16'h0, 16'h5A5A, "R3 data kept across self-refresh");
    check(rsp_cnt - rsp0 == 1, "R11 one response per read", rsp_cnt - rsp0, 1);

    // Aggregated per-cycle monitors
    check(v_addr == 0, "R2 address at and during chip enable low", v_addr, 0);
    check(v_read == 0, "R3 read strobe conditions", v_read, 0);
    check(v_strb == 0, "R4 strobes follow mask", v_strb, 0);
    check(v_drv == 0, "R5 driver inside strobe window", v_drv, 0);
    check(v_ce == 0, "R6 chip enable low and high widths", v_ce, 0);
    check(v_rf == 0, "R8 no ready while refreshing or sleeping", v_rf, 0);
    check(rsp_cnt == reads_issued, "R11 responses equal reads", rsp_cnt, reads_issued);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule